// File: doc/BRIEF.md
# Slow-Domain Register Write Synchronizer

This block sits on the fast bus clock and fronts a small bank of registers that live in a 32.768 kHz low-power domain. A bus write to one of these registers is captured at once, held while it crosses into the slow domain, and takes effect only after a fixed number of slow-clock rising edges. Software follows each write through four status flags. A busy flag shows that a write is still in flight. A next flag shows that a new write would be accepted. A complete flag shows that a write has landed. A sticky error flag shows that a write was attempted while the previous one was still in flight. In that case the new write is dropped, not queued.

The slow clock enters as a free-running input. A multi-stage synchronizer turns each of its rising edges into a single-cycle tick in the bus domain. The complete flag clears when the status register is read. The error flag clears only when a write of 1 to its bit in the status register has itself crossed into the slow domain. The interrupt-enable register is the exception to all of this: it is written at bus speed and never touches the flags. One interrupt line is the OR of each flag with its enable bit.

Top module: `lp_write_bridge`

## Requirements
- R1: After reset, the status register (address 8) reads 0x200, meaning only the next flag (bit 9) is set. The interrupt-enable register (address 9) and the four bank registers (addresses 0 to 3) read 0, and `irq` is low.
- R2: A write to a bank register or to the status register is accepted on a bus edge. Busy (status bit 10) reads 1 from the next cycle onward. The slow side counts one tick for each slow rising edge, and a tick is used on the third bus edge after that slow edge. The write commits on the bus edge that uses the 4th tick counted after acceptance, and only then does busy return to 0. Until the commit, a read of the target register returns its old value.
- R3: The next flag (bit 9) is the complement of busy. A write issued while next is 1, including one issued on the cycle right after a commit, is accepted without raising the error flag.
- R4: A commit stores the data into the addressed bank register and sets the complete flag (bit 8).
- R5: A read of the status register returns the complete flag as it stood, then clears it on that edge. If a commit lands on the same edge as the read, the flag stays set.
- R6: A write to address 9 takes effect on the next cycle. Bits 9, 8 and 7 of the written data are stored, and reads return only those bits. This write never sets busy, complete or error, even while a synchronized write is in flight.
- R7: A write to a bank register or to the status register while busy is 1 sets the sticky error flag (bit 7). That write is discarded, and the write already in flight commits its own data unchanged.
- R8: A status write with bit 7 = 1 is itself a synchronized write. The error flag stays set until that write commits and clears on the commit edge. A status write with bit 7 = 0 leaves the error flag set.
- R9: `irq` is high exactly when at least one of these holds: next with enable bit 9, complete with enable bit 8, or error with enable bit 7.
- R10: A write to an unmapped address (any address other than 0 to 3, 8 and 9) changes no flag and starts no write. A read from such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_clk | input | 1 | Free-running low-power-domain clock, asynchronous to clk |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe; clears the complete flag when it addresses the status register |
| addr | input | 4 | Register address for a read or a write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| irq | output | 1 | Interrupt, enabled flags ORed together |

## Verification
Writes are issued aligned to the slow clock. Status is sampled one cycle before the computed commit edge and then on it. This separates a correct tick count from one that commits a slow edge early or late, and it also lands a status read on the commit edge itself. Colliding writes are issued at random offsets inside the in-flight window, with fresh random data for the bank. This shows whether the second write is dropped, whether it corrupts the first, and whether it raises the error flag. Error-clear writes with bit 7 set and with bit 7 clear, a fast enable write made while busy, and an unmapped write show whether each path reaches the flags only through its own route. Random enable masks are checked against the interrupt line after each commit.

// File: rtl/lpw_pkg.sv
`timescale 1ns/1ps
package lpw_pkg;
  localparam int DATA_W   = 32;
  localparam int BUSY_BIT = 10;
  localparam int NEXT_BIT = 9;
  localparam int DONE_BIT = 8;
  localparam int ERR_BIT  = 7;

  typedef enum logic [1:0] {TGT_NONE, TGT_BANK, TGT_STAT, TGT_IEN} tgt_e;

  // address decode shared by the request side and the commit side
  function automatic tgt_e classify(input int a, input int nbank,
                                    input int stat_a, input int ien_a);
    if (a < nbank)   return TGT_BANK;
    if (a == stat_a) return TGT_STAT;
    if (a == ien_a)  return TGT_IEN;
    return TGT_NONE;
  endfunction

  // true when the tick now seen is the last one the write needs
  function automatic logic commit_due(input int seen, input logic tick, input int need);
    return tick && (seen + 1 == need);
  endfunction

  function automatic logic [DATA_W-1:0] pack_status(input logic busy, input logic done,
                                                    input logic err);
    logic [DATA_W-1:0] r;
    r = '0;
    r[BUSY_BIT] = busy;
    r[NEXT_BIT] = ~busy;
    r[DONE_BIT] = done;
    r[ERR_BIT]  = err;
    return r;
  endfunction

  // enable bits held as {next, done, err}
  function automatic logic [DATA_W-1:0] place_ien(input logic [2:0] e);
    logic [DATA_W-1:0] r;
    r = '0;
    r[NEXT_BIT] = e[2];
    r[DONE_BIT] = e[1];
    r[ERR_BIT]  = e[0];
    return r;
  endfunction
endpackage

// File: rtl/lpw_edge_sync.sv
`timescale 1ns/1ps
module lpw_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic tick
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], async_in};
  end

  // one bus cycle per slow rising edge, after STAGES flops of settling
  assign tick = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/lpw_write_track.sv
`timescale 1ns/1ps
module lpw_write_track
  import lpw_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int TICKS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              tick,
  output logic              busy,
  output logic              accept,
  output logic              collide,
  output logic              commit,
  output logic [ADDR_W-1:0] cm_addr,
  output logic [DATA_W-1:0] cm_data
);
  localparam int CW = $clog2(TICKS + 1);

  logic [CW-1:0] seen;

  assign accept  = req & ~busy;
  assign collide = req & busy;
  assign commit  = busy & commit_due(int'(32'(seen)), tick, TICKS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      seen    <= '0;
      cm_addr <= '0;
      cm_data <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      seen    <= '0;
      cm_addr <= req_addr;
      cm_data <= req_data;
    end else if (busy && tick) begin
      if (commit) begin
        busy <= 1'b0;
        seen <= '0;
      end else begin
        seen <= seen + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lpw_slow_bank.sv
`timescale 1ns/1ps
module lpw_slow_bank
  import lpw_pkg::*;
#(
  parameter int NUM_REGS = 4,
  localparam int IW      = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IW-1:0]     wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IW-1:0]     rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] word [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                           q <= '0;
      else if (we && wr_idx == IW'(i))      q <= wr_data;
    end
    assign word[i] = q;
  end

  assign rd_data = word[rd_idx];
endmodule

// File: rtl/lpw_flags.sv
`timescale 1ns/1ps
module lpw_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic       commit,
  input  logic       stat_commit,
  input  logic       err_clr_bit,
  input  logic       collide,
  input  logic       stat_read,
  input  logic       ien_we,
  input  logic [2:0] ien_wdata,
  output logic       done,
  output logic       err,
  output logic [2:0] ien,
  output logic       irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done <= 1'b0;
      err  <= 1'b0;
      ien  <= '0;
    end else begin
      // a landing commit outranks a clearing read
      if (commit)         done <= 1'b1;
      else if (stat_read) done <= 1'b0;
      // a fresh collision outranks a clearing commit
      if (collide)                         err <= 1'b1;
      else if (stat_commit && err_clr_bit) err <= 1'b0;
      if (ien_we) ien <= ien_wdata;
    end
  end

  assign irq = |({~busy, done, err} & ien);
endmodule

// File: rtl/lp_write_bridge.sv
`timescale 1ns/1ps
module lp_write_bridge
  import lpw_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int NUM_REGS    = 4,
  parameter int STAT_ADDR   = 8,
  parameter int IEN_ADDR    = 9,
  parameter int SYNC_TICKS  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_clk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int IW = $clog2(NUM_REGS);

  tgt_e              cur_tgt, cm_tgt;
  logic              tick, busy, accept, collide, commit;
  logic              sync_req, ien_we, stat_read, bank_we, stat_commit;
  logic              done, err;
  logic [2:0]        ien;
  logic [ADDR_W-1:0] cm_addr;
  logic [DATA_W-1:0] cm_data, bank_rd;

  assign cur_tgt     = classify(int'(32'(addr)), NUM_REGS, STAT_ADDR, IEN_ADDR);
  assign cm_tgt      = classify(int'(32'(cm_addr)), NUM_REGS, STAT_ADDR, IEN_ADDR);
  assign sync_req    = wr_en & ((cur_tgt == TGT_BANK) | (cur_tgt == TGT_STAT));
  assign ien_we      = wr_en & (cur_tgt == TGT_IEN);
  assign stat_read   = rd_en & (cur_tgt == TGT_STAT);
  assign bank_we     = commit & (cm_tgt == TGT_BANK);
  assign stat_commit = commit & (cm_tgt == TGT_STAT);

  lpw_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(slow_clk), .tick(tick)
  );

  lpw_write_track #(.ADDR_W(ADDR_W), .TICKS(SYNC_TICKS)) u_track (
    .clk(clk), .rst_n(rst_n), .req(sync_req), .req_addr(addr), .req_data(wdata),
    .tick(tick), .busy(busy), .accept(accept), .collide(collide), .commit(commit),
    .cm_addr(cm_addr), .cm_data(cm_data)
  );

  lpw_slow_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(bank_we), .wr_idx(cm_addr[IW-1:0]),
    .wr_data(cm_data), .rd_idx(addr[IW-1:0]), .rd_data(bank_rd)
  );

  lpw_flags u_flags (
    .clk(clk), .rst_n(rst_n), .busy(busy), .commit(commit),
    .stat_commit(stat_commit), .err_clr_bit(cm_data[ERR_BIT]),
    .collide(collide), .stat_read(stat_read), .ien_we(ien_we),
    .ien_wdata({wdata[NEXT_BIT], wdata[DONE_BIT], wdata[ERR_BIT]}),
    .done(done), .err(err), .ien(ien), .irq(irq)
  );

  always_comb begin
    unique case (cur_tgt)
      TGT_BANK: rdata = bank_rd;
      TGT_STAT: rdata = pack_status(busy, done, err);
      TGT_IEN:  rdata = place_ien(ien);
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/lp_write_bridge_chk.sv
`timescale 1ns/1ps
module lp_write_bridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       accept,
  input logic       busy,
  input logic       sync_req,
  input logic       commit,
  input logic       stat_read,
  input logic       ien_we,
  input logic       done,
  input logic       err,
  input logic [2:0] ien,
  input logic       irq
);
  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  assert_idle_no_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_req && !busy) |=> (err == $past(err)));

  assert_commit_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> done);

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_read && !commit) |=> !done);

  assert_ien_fast_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_we && !busy) |=> !busy);

  assert_collide_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_req && busy) |=> err);

  assert_err_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err) |-> $past(commit));

  assert_irq_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ien[2]) |-> irq);

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == 3'b000) |-> !irq);
endmodule

bind lp_write_bridge lp_write_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .busy(busy), .sync_req(sync_req),
  .commit(commit), .stat_read(stat_read), .ien_we(ien_we), .done(done),
  .err(err), .ien(ien), .irq(irq)
);

// File: tb/lp_write_bridge_bench.sv
`timescale 1ns/1ps
module lp_write_bridge_bench;
  localparam logic [3:0] A_STAT = 4'd8;
  localparam logic [3:0] A_IEN  = 4'd9;
  localparam logic [3:0] A_HOLE = 4'd5;
  localparam int         LAT    = 32;   // 4 slow periods of 8 bus cycles

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_clk = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int phase = 0;
  int cycles = 0;
  int s = 0;

  lp_write_bridge u_lp_write_bridge (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] exp_status(input bit b, input bit d, input bit e);
    return (32'(b) << 10) | (32'(!b) << 9) | (32'(d) << 8) | (32'(e) << 7);
  endfunction

  function automatic logic exp_irq(input bit b, input bit d, input bit e, input logic [31:0] m);
    return (!b && m[9]) || (d && m[8]) || (e && m[7]);
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  task automatic step();
    @(negedge clk);
    phase++;
    slow_clk = phase[2];
  endtask

  task automatic wait_to(input int t);
    while (phase < t) step();
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] v);
    rd_en = 1'b1; addr = a;
    #1 v = rdata;
    step();
    rd_en = 1'b0;
  endtask

  // issue a synchronized write three cycles after a slow rising edge
  task automatic sync_write(input logic [3:0] a, input logic [31:0] d);
    while (phase % 8 != 7) step();
    s = phase;
    bus_write(a, d);
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] bank [4];
    bit m_err;
    void'($urandom(32'd2718));
    for (int i = 0; i < 4; i++) bank[i] = '0;
    m_err = 0;
    repeat (5) step();
    rst_n = 1'b1;
    step();

    // reset state
    bus_read(A_STAT, v); chk(v, 32'h200, "R1 status after reset");
    bus_read(A_IEN, v);  chk(v, 32'h0, "R1 enable after reset");
    for (int i = 0; i < 4; i++) begin
      bus_read(4'(i), v); chk(v, 32'h0, "R1 bank after reset");
    end
    chk(32'(irq), 32'h0, "R1 irq after reset");

    // one aligned write followed through to its commit
    sync_write(4'd1, 32'hA5A5_0F0F);
    bus_read(A_STAT, v); chk(v, exp_status(1, 0, 0), "R2 busy after accept, R3 next low");
    bus_read(4'd1, v);   chk(v, 32'h0, "R2 old value before commit");
    wait_to(s + LAT - 1);
    bus_read(A_STAT, v); chk(v, exp_status(1, 0, 0), "R2 still busy one cycle before commit");
    bus_read(A_STAT, v); chk(v, exp_status(0, 1, 0), "R4 complete set, R5 kept by same-edge commit");
    bus_read(A_STAT, v); chk(v, exp_status(0, 0, 0), "R5 complete cleared by read");
    bus_read(4'd1, v);   chk(v, 32'hA5A5_0F0F, "R4 bank committed");
    bank[1] = 32'hA5A5_0F0F;

    // unaligned write right after idle is accepted cleanly
    bus_write(4'd3, 32'h1234_5678);
    bus_read(A_STAT, v); chk(v, exp_status(1, 0, 0), "R3 write accepted when next high");
    wait_to(phase + 48);
    bus_read(A_STAT, v); chk(v, exp_status(0, 1, 0), "R3 unaligned write completed");
    bank[3] = 32'h1234_5678;

    // fast enable register
    bus_write(A_IEN, 32'hFFFF_FFFF);
    chk(32'(irq), 32'h1, "R9 irq from next with bit 9 enabled");
    bus_read(A_IEN, v);  chk(v, 32'h380, "R6 enable readback bits 9..7");
    bus_read(A_STAT, v); chk(v, exp_status(0, 0, 0), "R6 enable write sets no flag");
    bus_write(A_IEN, 32'h100);
    chk(32'(irq), 32'h0, "R9 irq low with only complete enabled and clear");

    // enable write while busy, then collision
    sync_write(4'd2, 32'hCAFE_0002);
    bus_write(A_IEN, 32'h100);
    bus_read(A_STAT, v); chk(v, exp_status(1, 0, 0), "R6 enable write while busy raises no error");
    bus_write(4'd2, 32'hDEAD_BEEF);
    bus_read(A_STAT, v); chk(v, exp_status(1, 0, 1), "R7 collision sets error");
    chk(32'(irq), 32'h0, "R9 error not enabled");
    wait_to(s + LAT);
    chk(32'(irq), 32'h1, "R9 irq from complete with bit 8 enabled");
    bus_read(4'd2, v);   chk(v, 32'hCAFE_0002, "R7 in-flight data kept, second write dropped");
    bus_read(A_STAT, v); chk(v, exp_status(0, 1, 1), "R7 error sticky after commit");
    bank[2] = 32'hCAFE_0002;

    // error clearing
    sync_write(A_STAT, 32'h0);
    wait_to(s + LAT);
    bus_read(A_STAT, v); chk(v, exp_status(0, 1, 1), "R8 status write without bit 7 keeps error");
    sync_write(A_STAT, 32'h80);
    wait_to(s + LAT - 1);
    bus_read(A_STAT, v); chk(v, exp_status(1, 0, 1), "R8 error held until clear commits");
    bus_read(A_STAT, v); chk(v, exp_status(0, 1, 0), "R8 error cleared on commit");

    // unmapped address
    bus_write(A_HOLE, 32'hFFFF_FFFF);
    bus_read(A_STAT, v); chk(v, exp_status(0, 0, 0), "R10 unmapped write starts nothing");
    bus_read(A_HOLE, v); chk(v, 32'h0, "R10 unmapped read is zero");

    // constrained random writes, collisions and enable masks
    for (int it = 0; it < 40; it++) begin
      int idx, k, oth;
      bit coll;
      logic [31:0] d, d2, m;
      idx = $urandom_range(0, 3); oth = $urandom_range(0, 3);
      d = $urandom; d2 = $urandom; m = $urandom;
      coll = 1'($urandom_range(0, 1)); k = $urandom_range(1, 30);
      sync_write(4'(idx), d);
      if (coll) begin
        wait_to(s + k);
        bus_write(4'(idx), d2);
        m_err = 1;
      end
      wait_to(s + LAT);
      bus_read(A_STAT, v); chk(v, exp_status(0, 1, m_err), "R4 R7 random status after commit");
      bank[idx] = d;
      bus_read(4'(idx), v); chk(v, d, "R4 R7 random bank value");
      bus_read(4'(oth), v); chk(v, bank[oth], "R4 random other register kept");
      bus_write(A_IEN, m);
      chk(32'(irq), 32'(exp_irq(0, 0, m_err, m)), "R9 random enable mask");
      if (m_err) begin
        sync_write(A_STAT, 32'h80);
        wait_to(s + LAT);
        bus_read(A_STAT, v); chk(v, exp_status(0, 1, 0), "R8 random error clear");
        m_err = 0;
      end
    end

    summary();
  end
endmodule